// File: doc/BRIEF.md
# Pointer Signature and Authentication Unit

This block protects 64-bit code and data pointers by writing a short keyed signature into the upper pointer bits that a configured virtual address does not use. A sign request takes a pointer, a 64-bit modifier (or zero) and a key choice, and returns the pointer with its signature field filled in. An authenticate request recomputes the signature over the canonical form of the pointer. If it matches the stored field, the block returns the canonical address. If not, it returns an address that can never be valid, and a pass flag reports the outcome.

Four signing keys (instruction A/B, data A/B) and one general key, each 128 bits, are held in a bank. Software at privilege level 1 or above writes and reads the bank one 64-bit half at a time. A per-key enable input lets a key be switched off, and the operation then passes through unchanged. The signature comes from a fixed multi-round add/rotate/XOR mix of address, modifier and key. The result is registered one cycle after the request strobe.

Top module: `ptr_sign_unit`

## Requirements
- R1: After reset, res_valid, res_ok and res_ptr are all zero, and every key half reads back as zero.
- R2: A sign request with an enabled key returns, one cycle after req_valid, a pointer whose bits outside the signature field equal the input pointer (bit 55 included), with res_ok=1.
- R3: The signature field is bit positions 63 down to the effective width W, bit 55 excluded. W is va_bits clamped to the range 39..52.
- R4: Authenticating a signed pointer with the same key, modifier choice and width returns its canonical form: every field position is set to bit 55, the rest are unchanged, and res_ok=1.
- R5: If the stored field differs from the recomputed one, authentication gives res_ok=0 and returns the canonical form with bit 62 set to the inverse of bit 55. Bit 61 is also set to the inverse of bit 55 for key A (req_keyb=0) and equal to bit 55 for key B.
- R6: With req_mod_zero=1 the modifier input is ignored and zero is used in its place, so signing and authenticating with different req_mod values still pass.
- R7: The key is selected by {req_data, req_keyb} (0 instruction A, 1 instruction B, 2 data A, 3 data B), and key_en has one bit per key at that index. With the selected bit clear, both operations return the input pointer unchanged with res_ok=1.
- R8: kw_sel codes 0..4 name instruction A, instruction B, data A, data B and the general key, and kw_hi/kr_hi pick the upper 64-bit half. Writes happen only when priv_lvl is 1 or higher. At priv_lvl 0, kr_data reads as zero.
- R9: res_valid is high for exactly the cycle after each req_valid, and res_ptr and res_ok hold their values between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_auth | input | 1 | 1 authenticate, 0 sign |
| req_data | input | 1 | 1 data key, 0 instruction key |
| req_keyb | input | 1 | 1 key B, 0 key A |
| req_mod_zero | input | 1 | Use zero in place of req_mod |
| req_ptr | input | 64 | Pointer operand |
| req_mod | input | 64 | Modifier operand |
| va_bits | input | 6 | Configured virtual-address width |
| key_en | input | 4 | Per-key enables, indexed {req_data, req_keyb} |
| priv_lvl | input | 2 | Current privilege level |
| kw_en | input | 1 | Key half write strobe |
| kw_sel | input | 3 | Key select for write |
| kw_hi | input | 1 | Upper half select for write |
| kw_data | input | 64 | Write data |
| kr_sel | input | 3 | Key select for read |
| kr_hi | input | 1 | Upper half select for read |
| kr_data | output | 64 | Read data, zero at privilege 0 |
| res_valid | output | 1 | Result strobe |
| res_ptr | output | 64 | Signed, stripped or poisoned pointer |
| res_ok | output | 1 | Authentication passed |

## Verification
The failure path is the hardest case to reach. The signature is a keyed hash, so a mismatch cannot be predicted from arbitrary inputs, and a wrong modifier or key may still match by chance when the field is narrow. The stimulus therefore signs a pointer, takes the pointer the block returns, flips the lowest bit of its signature field (position W) and authenticates that. This mismatch is guaranteed for every width from 39 to 52, for each of the four keys and for pointers in both regions. The same sweep runs a clean round trip, so both outcomes are checked against values the bench computes from the field mask alone.

// File: rtl/ptr_sign_pkg.sv
package ptr_sign_pkg;
    localparam int PTR_W      = 64;
    localparam int HALF_W     = 64;
    localparam int NKEYS      = 5;
    localparam int REGION_BIT = 55;
    localparam int VA_MIN     = 39;
    localparam int VA_MAX     = 52;
    localparam int SEL_W      = $clog2(NKEYS);

    typedef enum logic [2:0] {
        KEY_INSN_A = 3'd0,
        KEY_INSN_B = 3'd1,
        KEY_DATA_A = 3'd2,
        KEY_DATA_B = 3'd3,
        KEY_GEN    = 3'd4
    } key_id_e;

    typedef struct packed {
        logic             valid;
        logic             ok;
        logic [PTR_W-1:0] ptr;
    } res_t;
endpackage

// File: rtl/ptr_key_bank.sv
module ptr_key_bank
    import ptr_sign_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              rd_hi,
    output logic [HALF_W-1:0] rd_data,
    input  logic [1:0]        op_sel,
    output logic [2*HALF_W-1:0] op_key
);
    logic [HALF_W-1:0] lo_d [NKEYS];
    logic [HALF_W-1:0] lo_q [NKEYS];
    logic [HALF_W-1:0] hi_d [NKEYS];
    logic [HALF_W-1:0] hi_q [NKEYS];

    always_comb begin
        for (int k = 0; k < NKEYS; k++) begin
            lo_d[k] = lo_q[k];
            hi_d[k] = hi_q[k];
            if (wr_en && (int'(wr_sel) == k)) begin
                if (wr_hi) hi_d[k] = wr_data;
                else       lo_d[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NKEYS; k++) begin
                lo_q[k] <= '0;
                hi_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NKEYS; k++) begin
                lo_q[k] <= lo_d[k];
                hi_q[k] <= hi_d[k];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NKEYS; k++) begin
            if (int'(rd_sel) == k) rd_data = rd_hi ? hi_q[k] : lo_q[k];
        end
    end

    assign op_key = {hi_q[op_sel], lo_q[op_sel]};
endmodule

// File: rtl/ptr_field_mask.sv
module ptr_field_mask
    import ptr_sign_pkg::*;
(
    input  logic [5:0]       va_bits,
    output logic [PTR_W-1:0] mask
);
    logic [5:0] eff;

    always_comb begin
        if (int'(va_bits) < VA_MIN)      eff = 6'(VA_MIN);
        else if (int'(va_bits) > VA_MAX) eff = 6'(VA_MAX);
        else                             eff = va_bits;
    end

    for (genvar i = 0; i < PTR_W; i++) begin : g_bit
        if (i == REGION_BIT) begin : g_region
            assign mask[i] = 1'b0;
        end else begin : g_sig
            assign mask[i] = (i >= int'(eff));
        end
    end
endmodule

// File: rtl/ptr_mix.sv
module ptr_mix
    import ptr_sign_pkg::*;
#(
    parameter int ROUNDS = 4
) (
    input  logic [PTR_W-1:0]    addr,
    input  logic [PTR_W-1:0]    modv,
    input  logic [2*HALF_W-1:0] key,
    output logic [PTR_W-1:0]    tag
);
    localparam int ROT_A = 13;
    localparam int ROT_B = 29;

    function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
        return (x << n) | (x >> (64 - n));
    endfunction

    logic [63:0] a_s [ROUNDS+1];
    logic [63:0] b_s [ROUNDS+1];

    assign a_s[0] = addr ^ key[HALF_W-1:0];
    assign b_s[0] = modv ^ key[2*HALF_W-1:HALF_W];

    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
        logic [63:0] sum;
        assign sum        = a_s[r] + b_s[r];
        assign a_s[r+1]   = rotl(sum, ROT_A) ^ key[HALF_W-1:0];
        assign b_s[r+1]   = rotl(b_s[r] ^ a_s[r+1], ROT_B)
                          + key[2*HALF_W-1:HALF_W] + 64'(r + 1);
    end

    assign tag = a_s[ROUNDS] ^ b_s[ROUNDS];
endmodule

// File: rtl/ptr_sign_unit.sv
module ptr_sign_unit
    import ptr_sign_pkg::*;
#(
    parameter int MIX_ROUNDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_auth,
    input  logic              req_data,
    input  logic              req_keyb,
    input  logic              req_mod_zero,
    input  logic [PTR_W-1:0]  req_ptr,
    input  logic [PTR_W-1:0]  req_mod,
    input  logic [5:0]        va_bits,
    input  logic [3:0]        key_en,
    input  logic [1:0]        priv_lvl,
    input  logic              kw_en,
    input  logic [SEL_W-1:0]  kw_sel,
    input  logic              kw_hi,
    input  logic [HALF_W-1:0] kw_data,
    input  logic [SEL_W-1:0]  kr_sel,
    input  logic              kr_hi,
    output logic [HALF_W-1:0] kr_data,
    output logic              res_valid,
    output logic [PTR_W-1:0]  res_ptr,
    output logic              res_ok
);
    logic                priv_ok;
    logic [HALF_W-1:0]   bank_rd;
    logic [1:0]          op_sel;
    logic [2*HALF_W-1:0] op_key;
    logic [PTR_W-1:0]    mask;
    logic [PTR_W-1:0]    canon;
    logic [PTR_W-1:0]    mod_eff;
    logic [PTR_W-1:0]    tag;
    logic [PTR_W-1:0]    signed_ptr;
    logic [PTR_W-1:0]    poison;
    logic                match;
    logic                key_on;
    res_t                st_d, st_q;

    assign priv_ok = (priv_lvl != 2'd0);
    assign op_sel  = {req_data, req_keyb};

    ptr_key_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (kw_en && priv_ok),
        .wr_sel  (kw_sel),
        .wr_hi   (kw_hi),
        .wr_data (kw_data),
        .rd_sel  (kr_sel),
        .rd_hi   (kr_hi),
        .rd_data (bank_rd),
        .op_sel  (op_sel),
        .op_key  (op_key)
    );

    ptr_field_mask u_mask (
        .va_bits (va_bits),
        .mask    (mask)
    );

    ptr_mix #(.ROUNDS(MIX_ROUNDS)) u_mix (
        .addr (canon),
        .modv (mod_eff),
        .key  (op_key),
        .tag  (tag)
    );

    always_comb begin
        canon      = (req_ptr & ~mask) | ({PTR_W{req_ptr[REGION_BIT]}} & mask);
        mod_eff    = req_mod_zero ? '0 : req_mod;
        signed_ptr = (req_ptr & ~mask) | (tag & mask);
        match      = (((req_ptr ^ tag) & mask) == '0);
        key_on     = key_en[op_sel];
        poison     = canon;
        poison[62] = ~req_ptr[REGION_BIT];
        poison[61] = req_keyb ? req_ptr[REGION_BIT] : ~req_ptr[REGION_BIT];

        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            if (!key_on) begin
                st_d.ptr = req_ptr;
                st_d.ok  = 1'b1;
            end else if (req_auth) begin
                st_d.ptr = match ? canon : poison;
                st_d.ok  = match;
            end else begin
                st_d.ptr = signed_ptr;
                st_d.ok  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign kr_data   = priv_ok ? bank_rd : '0;
    assign res_valid = st_q.valid;
    assign res_ptr   = st_q.ptr;
    assign res_ok    = st_q.ok;
endmodule

// File: rtl/ptr_sign_chk.sv
module ptr_sign_chk
    import ptr_sign_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_auth,
    input logic              req_data,
    input logic              req_keyb,
    input logic [PTR_W-1:0]  req_ptr,
    input logic [3:0]        key_en,
    input logic [1:0]        priv_lvl,
    input logic [HALF_W-1:0] kr_data,
    input logic              res_valid,
    input logic [PTR_W-1:0]  res_ptr,
    input logic              res_ok
);
    // R9: result strobe follows request strobe by one cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R9: result holds between requests
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_ptr) && $stable(res_ok)));
    // R2: region bit is never changed by any operation
    a_r2_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_ptr[REGION_BIT] == $past(req_ptr[REGION_BIT])));
    // R2: signing always reports success
    a_r2_sign_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_auth) |=> res_ok);
    // R5: a failed result is never canonical
    a_r5_poison: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ok) |-> (res_ptr[62] != res_ptr[REGION_BIT]));
    // R7: a disabled key never reports failure
    a_r7_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !key_en[{req_data, req_keyb}]) |=> res_ok);
    // R8: no key material visible at privilege 0
    a_r8_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == 2'd0) |-> (kr_data == '0));
endmodule

bind ptr_sign_unit ptr_sign_chk chk_i (.*);

// File: tb/ptr_sign_unit_tb_top.sv
module ptr_sign_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_auth = 1'b0, req_data = 1'b0, req_keyb = 1'b0;
    logic        req_mod_zero = 1'b0;
    logic [63:0] req_ptr = '0, req_mod = '0;
    logic [5:0]  va_bits = 6'd48;
    logic [3:0]  key_en = 4'hF;
    logic [1:0]  priv_lvl = 2'd1;
    logic        kw_en = 1'b0;
    logic [2:0]  kw_sel = '0;
    logic        kw_hi = 1'b0;
    logic [63:0] kw_data = '0;
    logic [2:0]  kr_sel = '0;
    logic        kr_hi = 1'b0;
    logic [63:0] kr_data;
    logic        res_valid;
    logic [63:0] res_ptr;
    logic        res_ok;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ptr_sign_unit dut_i (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] fmask(input int va);
        int w;
        logic [63:0] m;
        w = (va < 39) ? 39 : (va > 52) ? 52 : va;
        m = '0;
        for (int i = w; i < 64; i++) if (i != 55) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] strip(input logic [63:0] p, input int va);
        logic [63:0] m;
        m = fmask(va);
        return (p & ~m) | ({64{p[55]}} & m);
    endfunction

    task automatic kwrite(input logic [1:0] pl, input logic [2:0] s, input logic h, input logic [63:0] d);
        @(negedge clk);
        priv_lvl = pl; kw_en = 1'b1; kw_sel = s; kw_hi = h; kw_data = d;
        @(negedge clk);
        kw_en = 1'b0; priv_lvl = 2'd1;
    endtask

    task automatic op(input logic auth, input logic [1:0] k, input logic mz,
                      input logic [63:0] p, input logic [63:0] m, input int va);
        @(negedge clk);
        req_valid = 1'b1; req_auth = auth; req_data = k[1]; req_keyb = k[0];
        req_mod_zero = mz; req_ptr = p; req_mod = m; va_bits = 6'(va);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] ptrs [3];
        logic [63:0] sp, exp, hold;
        ptrs[0] = 64'h0000_0ABC_DEF1_2345;
        ptrs[1] = 64'hFFFF_F9AB_CDEF_0124;
        ptrs[2] = 64'h00F0_0000_1234_5678;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 res_valid", 64'(res_valid), 64'd0);
        check("R1 res_ok", 64'(res_ok), 64'd0);
        check("R1 res_ptr", res_ptr, 64'd0);
        rst_n = 1'b1;
        kr_sel = 3'd2; kr_hi = 1'b1; #1;
        check("R1 key reset", kr_data, 64'd0);

        // R8 key bank access
        for (int s = 0; s < 5; s++) begin
            kwrite(2'd1, 3'(s), 1'b0, 64'h1111_2222_3333_4444 * 64'(s + 3));
            kwrite(2'd2, 3'(s), 1'b1, 64'h9E37_79B9_7F4A_7C15 ^ 64'(s * 977));
        end
        for (int s = 0; s < 5; s++) begin
            @(negedge clk); kr_sel = 3'(s); kr_hi = 1'b0; #1;
            check("R8 read lo", kr_data, 64'h1111_2222_3333_4444 * 64'(s + 3));
            kr_hi = 1'b1; #1;
            check("R8 read hi", kr_data, 64'h9E37_79B9_7F4A_7C15 ^ 64'(s * 977));
        end
        kwrite(2'd0, 3'd4, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
        @(negedge clk); kr_sel = 3'd4; kr_hi = 1'b1; #1;
        check("R8 priv0 write ignored", kr_data, 64'h9E37_79B9_7F4A_7C15 ^ 64'(4 * 977));
        priv_lvl = 2'd0; #1;
        check("R8 priv0 read zero", kr_data, 64'd0);
        priv_lvl = 2'd1;

        // R2 R3 R4 R5 sweep over widths, pointers, keys
        for (int va = 39; va <= 52; va++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int k = 0; k < 4; k++) begin
                    op(1'b0, 2'(k), 1'b0, ptrs[pi], 64'h7FFF_FFF0_0000_1230 + 64'(va), va);
                    check("R2 valid", 64'(res_valid), 64'd1);
                    check("R2 sign ok", 64'(res_ok), 64'd1);
                    check("R3 outside field", res_ptr & ~fmask(va), ptrs[pi] & ~fmask(va));
                    sp = res_ptr;
                    op(1'b1, 2'(k), 1'b0, sp, 64'h7FFF_FFF0_0000_1230 + 64'(va), va);
                    check("R4 auth ok", 64'(res_ok), 64'd1);
                    check("R4 stripped", res_ptr, strip(ptrs[pi], va));
                    sp[va] = ~sp[va];
                    op(1'b1, 2'(k), 1'b0, sp, 64'h7FFF_FFF0_0000_1230 + 64'(va), va);
                    exp = strip(sp, va);
                    exp[62] = ~sp[55];
                    exp[61] = k[0] ? sp[55] : ~sp[55];
                    check("R5 fail flag", 64'(res_ok), 64'd0);
                    check("R5 poisoned", res_ptr, exp);
                end
            end
        end

        // R3 width clamping: below range acts as 39, above as 52
        op(1'b0, 2'd2, 1'b0, ptrs[0], 64'h55, 30);
        check("R3 clamp low", res_ptr & ~fmask(39), ptrs[0] & ~fmask(39));
        sp = res_ptr;
        op(1'b1, 2'd2, 1'b0, sp, 64'h55, 39);
        check("R3 clamp low auth", {63'd0, res_ok}, 64'd1);
        op(1'b0, 2'd1, 1'b0, ptrs[1], 64'h66, 60);
        sp = res_ptr;
        op(1'b1, 2'd1, 1'b0, sp, 64'h66, 52);
        check("R3 clamp high auth", {63'd0, res_ok}, 64'd1);
        check("R3 clamp high ptr", res_ptr, strip(ptrs[1], 52));

        // R6 zero modifier ignores req_mod
        for (int k = 0; k < 4; k++) begin
            op(1'b0, 2'(k), 1'b1, ptrs[2], 64'h1234, 44);
            sp = res_ptr;
            op(1'b1, 2'(k), 1'b1, sp, 64'hFEDC_BA98_0000_0001, 44);
            check("R6 mod zero ok", {63'd0, res_ok}, 64'd1);
            check("R6 mod zero ptr", res_ptr, strip(ptrs[2], 44));
        end

        // R7 disabled key passes through
        for (int k = 0; k < 4; k++) begin
            key_en = ~(4'b1 << k);
            op(1'b0, 2'(k), 1'b0, ptrs[1], 64'h9, 40);
            check("R7 sign passthrough", res_ptr, ptrs[1]);
            op(1'b1, 2'(k), 1'b0, ptrs[2] ^ 64'h0100_0000_0000_0000, 64'h9, 40);
            check("R7 auth passthrough", res_ptr, ptrs[2] ^ 64'h0100_0000_0000_0000);
            check("R7 auth ok", {63'd0, res_ok}, 64'd1);
        end
        key_en = 4'hF;

        // R9 strobe and hold
        op(1'b0, 2'd0, 1'b0, ptrs[0], 64'h3, 48);
        hold = res_ptr;
        repeat (3) @(negedge clk);
        check("R9 strobe low", 64'(res_valid), 64'd0);
        check("R9 hold", res_ptr, hold);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule